// File: doc/BRIEF.md
# Two-Level Nesting Interrupt Controller

This block chooses among five interrupt sources: two external inputs, two timers and one serial port. For each source, the request flag is combined with its own enable bit and with one global enable bit. The source's priority bit then places the request in either the high level or the low level. Arbitration runs once per machine-cycle strobe. When an interrupt is taken, the block gives a one-clock acknowledge to the chosen source and a one-clock vector request. At the same time it loads a fixed vector address.

The controller keeps one in-service bit for each level, which allows a single level of nesting. A high request can interrupt a low service. A low request cannot interrupt anything that is already in service. A request at the same level as the active service waits. A return-from-interrupt pulse ends the innermost active service. Taking an interrupt does not change the global enable. The enable and priority registers are held outside the block and feed it directly.

Top module: `irq_nest_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, ack_o is 0, vec_req_o is 0, both in-service outputs are 0 and vec_addr_o is 0000h.
- R2: When en_reg bit 7 (global enable) is 0, no interrupt is taken, whatever the per-source enable bits hold.
- R3: A source is considered only when its enable bit is 1. The enable bits are en_reg bit 0 = ext0, bit 1 = timer0, bit 2 = ext1, bit 3 = timer1, bit 4 = serial. Bits 6 and 5 have no effect.
- R4: pri_reg uses the same bit order as the enable bits, with 1 meaning high level. An eligible high-level request wins over every low-level request in the same strobe.
- R5: Among eligible requests of the same level, the winner is the lowest bit index: ext0, then timer0, then ext1, then timer1, then serial.
- R6: The vector address is loaded with 0003h + 8 × source index: ext0 0003h, timer0 000Bh, ext1 0013h, timer1 001Bh, serial 0023h. It holds until the next grant.
- R7: A grant is made only in a cycle where mcyc_stb is 1. In the following cycle ack_o is one-hot on the winner and vec_req_o is 1. Both last exactly one clock.
- R8: A granted high-level source sets insvc_hi_o and a granted low-level source sets insvc_lo_o. A high-level request is taken while only a low service is active.
- R9: While insvc_hi_o is 1, no request is taken. While only insvc_lo_o is 1, low-level requests are not taken.
- R10: A reti_i pulse clears insvc_hi_o if it is set, otherwise it clears insvc_lo_o. After the return, new requests are taken again with no change to the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcyc_stb | input | 1 | Machine-cycle strobe; arbitration happens on cycles where it is 1 |
| req_i | input | 5 | Request flags, bit 0 ext0 … bit 4 serial |
| en_reg | input | 8 | Enable register: bit 7 global, bits 4..0 per source |
| pri_reg | input | 5 | Priority bits per source, 1 = high level |
| reti_i | input | 1 | Return-from-interrupt pulse |
| vec_req_o | output | 1 | One-clock vector request |
| vec_addr_o | output | 16 | Vector address of the last granted source |
| ack_o | output | 5 | One-clock, one-hot acknowledge to the granted source |
| insvc_hi_o | output | 1 | High-level service active |
| insvc_lo_o | output | 1 | Low-level service active |

## Verification
The assertions assume that reti_i is pulsed only while at least one service is active. They also assume that the request flags are cleared by logic outside the block, so a source that stays requesting after its acknowledge is simply held off by the in-service rules. The bench follows these rules. Every stimulus vector starts from an idle state, and after any grant the bench issues exactly as many returns as there are active levels. The bench also changes inputs only on the falling edge and raises the strobe for a single cycle at a time, so each strobe produces at most one grant.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NSRC    = 5;
  localparam int GLB_BIT = 7;
  localparam int EN_W    = 8;
  localparam int IDX_W   = $clog2(NSRC);
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_nest_pkg::*;
(
  input  src_vec_t req,
  input  src_vec_t src_en,
  input  logic     glb_en,
  input  src_vec_t pri,
  output src_vec_t hi_cand,
  output src_vec_t lo_cand
);
  src_vec_t live;

  always_comb begin
    live    = req & src_en & {NSRC{glb_en}};
    hi_cand = live & pri;
    lo_cand = live & ~pri;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] pick,
  output logic         any
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chain
      assign pick[i]   = cand[i] & ~seen[i];
      assign seen[i+1] = seen[i] | cand[i];
    end
  endgenerate
  assign any = seen[N];
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic clk,
  input  logic rst,
  input  logic grant_hi,
  input  logic grant_lo,
  input  logic reti,
  output logic hi_q,
  output logic lo_q
);
  logic hi_n, lo_n;

  always_comb begin
    hi_n = hi_q;
    lo_n = lo_q;
    if (reti) begin
      if (hi_q) hi_n = 1'b0;
      else      lo_n = 1'b0;
    end
    if (grant_hi) hi_n = 1'b1;
    if (grant_lo) lo_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_n;
      lo_q <= lo_n;
    end
  end

  AST_RETI_HI_FIRST: assert property (@(posedge clk) disable iff (rst)
    reti && hi_q |=> !hi_q && (lo_q == $past(lo_q))) else $error("reti order"); // R10
  AST_GRANT_SETS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    grant_lo |=> lo_q) else $error("lo grant lost"); // R8
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int               VEC_W      = 16,
  parameter logic [VEC_W-1:0] VEC_BASE   = 16'h0003,
  parameter int               VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mcyc_stb,
  input  logic [NSRC-1:0]  req_i,
  input  logic [EN_W-1:0]  en_reg,
  input  logic [NSRC-1:0]  pri_reg,
  input  logic             reti_i,
  output logic             vec_req_o,
  output logic [VEC_W-1:0] vec_addr_o,
  output logic [NSRC-1:0]  ack_o,
  output logic             insvc_hi_o,
  output logic             insvc_lo_o
);
  localparam logic [VEC_W-1:0] STEP = VEC_W'(VEC_STRIDE);

  src_vec_t hi_cand, lo_cand, hi_pick, lo_pick, grant;
  logic     hi_any, lo_any, take_hi, take_lo;
  logic [IDX_W-1:0] idx;
  logic [VEC_W-1:0] vaddr_n;
  logic unused_en_bits;

  assign unused_en_bits = ^en_reg[GLB_BIT-1:NSRC];

  irq_mask_unit mask_i (
    .req     (req_i),
    .src_en  (en_reg[NSRC-1:0]),
    .glb_en  (en_reg[GLB_BIT]),
    .pri     (pri_reg),
    .hi_cand (hi_cand),
    .lo_cand (lo_cand)
  );

  irq_prio_pick #(.N(NSRC)) pick_hi_i (.cand(hi_cand), .pick(hi_pick), .any(hi_any));
  irq_prio_pick #(.N(NSRC)) pick_lo_i (.cand(lo_cand), .pick(lo_pick), .any(lo_any));

  always_comb begin
    take_hi = mcyc_stb & ~insvc_hi_o & hi_any;
    take_lo = mcyc_stb & ~insvc_hi_o & ~insvc_lo_o & lo_any & ~hi_any;
    if (take_hi)      grant = hi_pick;
    else if (take_lo) grant = lo_pick;
    else              grant = '0;
    idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) idx = IDX_W'(i);
    vaddr_n = VEC_BASE + VEC_W'(idx) * STEP;
  end

  irq_svc_track svc_i (
    .clk      (clk),
    .rst      (rst),
    .grant_hi (take_hi),
    .grant_lo (take_lo),
    .reti     (reti_i),
    .hi_q     (insvc_hi_o),
    .lo_q     (insvc_lo_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o      <= '0;
      vec_req_o  <= 1'b0;
      vec_addr_o <= '0;
    end else begin
      ack_o     <= grant;
      vec_req_o <= take_hi | take_lo;
      if (take_hi | take_lo) vec_addr_o <= vaddr_n;
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_o)) else $error("ack not onehot"); // R7
  AST_REQ_TRACKS_ACK: assert property (@(posedge clk) disable iff (rst)
    vec_req_o == (ack_o != '0)) else $error("vec_req/ack mismatch"); // R7
  AST_NO_STB_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    !mcyc_stb |=> !vec_req_o) else $error("grant without strobe"); // R7
  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
    mcyc_stb && !en_reg[GLB_BIT] |=> ack_o == '0) else $error("global off ignored"); // R2
  AST_ACK_WAS_ENABLED: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> (ack_o & $past(req_i & en_reg[NSRC-1:0])) != '0) else $error("ack to disabled"); // R3
  AST_HI_BLOCKS_ALL: assert property (@(posedge clk) disable iff (rst)
    mcyc_stb && insvc_hi_o |=> !vec_req_o) else $error("preempted high"); // R9
  AST_LO_ONLY_HI: assert property (@(posedge clk) disable iff (rst)
    mcyc_stb && insvc_lo_o && !insvc_hi_o |=> !vec_req_o || insvc_hi_o) else $error("same-level nest"); // R8
endmodule

// File: tb/irq_nest_ctrl_tb_top.sv
module irq_nest_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mcyc_stb = 1'b0;
  logic [4:0]  req_i = '0;
  logic [7:0]  en_reg = '0;
  logic [4:0]  pri_reg = '0;
  logic        reti_i = 1'b0;
  logic        vec_req_o;
  logic [15:0] vec_addr_o;
  logic [4:0]  ack_o;
  logic        insvc_hi_o, insvc_lo_o;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_nest_ctrl dut_i (
    .clk(clk), .rst(rst), .mcyc_stb(mcyc_stb), .req_i(req_i), .en_reg(en_reg),
    .pri_reg(pri_reg), .reti_i(reti_i), .vec_req_o(vec_req_o), .vec_addr_o(vec_addr_o),
    .ack_o(ack_o), .insvc_hi_o(insvc_hi_o), .insvc_lo_o(insvc_lo_o)
  );

  typedef struct packed {
    logic [7:0] en;
    logic [4:0] pri;
    logic [4:0] req;
    logic [4:0] exp_ack;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TABLE [NV] = '{
    '{8'h9F, 5'b00000, 5'b11111, 5'b00001},  // R5 ext0 first
    '{8'h9E, 5'b00000, 5'b11111, 5'b00010},  // R3 ext0 masked
    '{8'h9C, 5'b00000, 5'b11110, 5'b00100},  // R5
    '{8'h98, 5'b00000, 5'b11111, 5'b01000},  // R3
    '{8'h90, 5'b00000, 5'b11111, 5'b10000},  // R6 serial
    '{8'h1F, 5'b00000, 5'b11111, 5'b00000},  // R2 global off
    '{8'h9F, 5'b10000, 5'b11111, 5'b10000},  // R4 high serial wins
    '{8'h9F, 5'b01010, 5'b11111, 5'b00010},  // R4/R5 within high
    '{8'h9F, 5'b00000, 5'b00000, 5'b00000},  // R7 no request
    '{8'hFF, 5'b11111, 5'b10100, 5'b00100},  // R3 bits 6,5 ignored
    '{8'h9F, 5'b00100, 5'b10001, 5'b00001},  // R4 high not requesting
    '{8'h8F, 5'b10000, 5'b10000, 5'b00000}   // R3 serial disabled
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) mcyc_stb = 1'b1;
    @(negedge clk) mcyc_stb = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk) reti_i = 1'b1;
    @(negedge clk) reti_i = 1'b0;
  endtask

  function automatic logic [15:0] vaddr_of(input logic [4:0] oh);
    for (int i = 0; i < 5; i++)
      if (oh[i]) return 16'h0003 + 16'(8 * i);
    return 16'h0000;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] last_addr;
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", 32'(ack_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ack", 32'(ack_o), 0);
    chk("R1 vec_req", 32'(vec_req_o), 0);
    chk("R1 insvc", 32'({insvc_hi_o, insvc_lo_o}), 0);
    chk("R1 vec_addr", 32'(vec_addr_o), 0);

    last_addr = 16'h0000;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      en_reg = TABLE[v].en; pri_reg = TABLE[v].pri; req_i = TABLE[v].req;
      strobe();
      chk($sformatf("R5 vec%0d ack", v), 32'(ack_o), 32'(TABLE[v].exp_ack));
      chk($sformatf("R7 vec%0d vec_req", v), 32'(vec_req_o), 32'(TABLE[v].exp_ack != 0));
      if (TABLE[v].exp_ack != 0) last_addr = vaddr_of(TABLE[v].exp_ack);
      chk($sformatf("R6 vec%0d addr", v), 32'(vec_addr_o), 32'(last_addr));
      @(negedge clk);
      chk($sformatf("R7 vec%0d pulse width", v), 32'(ack_o), 0);
      req_i = '0;
      if (TABLE[v].exp_ack != 0) ret();
      chk($sformatf("R10 vec%0d idle", v), 32'({insvc_hi_o, insvc_lo_o}), 0);
    end

    // R7: requests without strobe are not taken
    en_reg = 8'h9F; pri_reg = 5'b00100; req_i = 5'b00001;
    repeat (3) @(negedge clk);
    chk("R7 no strobe no ack", 32'(vec_req_o), 0);

    // R8: low ext0 then high ext1 nests
    strobe();
    chk("R8 low grant ack", 32'(ack_o), 32'h01);
    chk("R8 low insvc", 32'({insvc_hi_o, insvc_lo_o}), 32'b01);
    req_i = 5'b00101;
    strobe();
    chk("R8 high preempts", 32'(ack_o), 32'h04);
    chk("R6 ext1 vector", 32'(vec_addr_o), 32'h13);
    chk("R8 both insvc", 32'({insvc_hi_o, insvc_lo_o}), 32'b11);

    // R9: nothing taken while high active
    req_i = 5'b11111;
    strobe();
    chk("R9 hold under high", 32'(vec_req_o), 0);

    // R10: return clears high first
    ret();
    chk("R10 hi cleared first", 32'({insvc_hi_o, insvc_lo_o}), 32'b01);

    // R9: same-level low waits
    req_i = 5'b00001;
    strobe();
    chk("R9 same level waits", 32'(vec_req_o), 0);
    req_i = 5'b00100;
    strobe();
    chk("R8 high preempts again", 32'(ack_o), 32'h04);
    ret();
    ret();
    chk("R10 all cleared", 32'({insvc_hi_o, insvc_lo_o}), 0);

    // R9: low cannot preempt high
    req_i = 5'b00100;
    strobe();
    chk("R8 high alone", 32'({insvc_hi_o, insvc_lo_o}), 32'b10);
    req_i = 5'b00001;
    strobe();
    chk("R9 low under high", 32'(vec_req_o), 0);
    ret();
    strobe();
    chk("R10 taken after return", 32'(ack_o), 32'h01);
    ret();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule